// File: doc/BRIEF.md
# Cascaded Interface Clock Generator

This block derives two slow rates from the system clock for an external memory interface. All of its logic runs on the system clock. The first stage produces a timing tick, a one-cycle enable at either the full or the half system rate. The second stage counts those ticks and defines the external bus clock period as either one or two timing periods. The external clock appears on a registered pin as a square wave that is high for the first half of each period. The block also drives a one-cycle access-start strobe on the first system cycle of every external period. A bus sequencer uses that strobe to begin each access on a rising edge of the external clock.

Three configuration inputs select the stage ratios and gate the pin off. The block samples all three only on the last system cycle of an external period, so a live change is never seen in the middle of a period. When the pin is gated off, it is held low. The timing tick and the access strobe keep running while the pin is off.

Top module: `bclk_gen`

## Requirements
- R1: While rst_ni is low, tim_tick_o, xclk_o and acc_start_o are all 0. The active configuration resets to: timing stage halved, external stage halved, pin enabled.
- R2: With the timing stage at full rate (tim_div2_i = 0 active), tim_tick_o is 1 on every system cycle.
- R3: With the timing stage halved (tim_div2_i = 1 active), tim_tick_o is 1 on every second system cycle. The tick falls on the second cycle of each pair, counted from the start of the external period, and never on two consecutive cycles.
- R4: The external period in system cycles is 1 or 2 (from the timing stage) multiplied by 1 or 2 (from ext_div2_i = 0 or 1). Whenever that period is longer than one cycle, two acc_start_o pulses are never adjacent.
- R5: After reset, with the inputs at their default values, acc_start_o pulses every 4 system cycles, and xclk_o is high for 2 cycles and low for 2.
- R6: While the active clock-off setting is 1 (from ext_off_i = 1), xclk_o is 0. tim_tick_o and acc_start_o continue unchanged.
- R7: The block samples the configuration inputs only on the last system cycle of an external period, and the new values govern the outputs from the next period on. A change at any other time has no effect on the current period.
- R8: acc_start_o is 1 for exactly the first system cycle of each external period. Every rising edge of xclk_o coincides with an acc_start_o pulse.
- R9: With both stages at full rate, the external period is one system cycle. In that case acc_start_o is 1 on every cycle and xclk_o is held high, unless the pin is gated off.
- R10: For external periods of 2 or 4 cycles, xclk_o is high for the first half of the period and low for the second half.
- R11: All three outputs are registered. Each one shows the state of the preceding system cycle, a latency of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tim_div2_i | input | 1 | 1: timing tick at half the system rate; 0: full rate |
| ext_div2_i | input | 1 | 1: external period is two timing periods; 0: one |
| ext_off_i | input | 1 | 1: hold the external clock pin low |
| tim_tick_o | output | 1 | One-cycle timing tick |
| xclk_o | output | 1 | External bus clock pin |
| acc_start_o | output | 1 | Strobe on the first cycle of each external period |

## Verification
The assertions assume that the configuration inputs are synchronous to clk_i and settle before each rising edge. They also assume that a pending change is meant to take effect at a period boundary, not at once. The bench drives the inputs on the falling edge, so every value is stable at the sampling edge. It mixes directed holds of each ratio combination with random toggling. The random toggling is weighted so that some changes land mid-period and must be deferred.

// File: rtl/bclk_pkg.sv
package bclk_pkg;
  localparam int unsigned NSTG = 2;

  typedef struct packed {
    logic            off;
    logic [NSTG-1:0] half;
  } bclk_cfg_t;

  localparam bclk_cfg_t CFG_RST = '{off: 1'b0, half: {NSTG{1'b1}}};
endpackage

// File: rtl/bclk_div_stage.sv
module bclk_div_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic half_i,
  output logic tick_o,
  output logic at_first_o
);
  logic ph_q;

  assign tick_o     = en_i & (~half_i | ph_q);
  assign at_first_o = ~ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ph_q <= 1'b0;
    else if (en_i) ph_q <= half_i & ~ph_q;
  end

  a_r3_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && half_i) |=> !(tick_o && half_i));
endmodule

// File: rtl/bclk_cfg_hold.sv
module bclk_cfg_hold
  import bclk_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  bclk_cfg_t cfg_i,
  output bclk_cfg_t cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_o <= CFG_RST;
    else if (load_i) cfg_o <= cfg_i;
  end
endmodule

// File: rtl/bclk_out_shaper.sv
module bclk_out_shaper
  import bclk_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick0_i,
  input  logic [NSTG-1:0] at_first_i,
  input  logic [NSTG-1:0] half_i,
  input  logic            off_i,
  output logic            tim_tick_o,
  output logic            xclk_o,
  output logic            start_o
);
  logic lvl;
  logic start;

  // highest halved stage decides the high half of the period
  always_comb begin
    lvl = 1'b1;
    for (int i = 0; i < NSTG; i++) begin
      if (half_i[i]) lvl = at_first_i[i];
    end
  end

  assign start = &at_first_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tim_tick_o <= 1'b0;
      xclk_o     <= 1'b0;
      start_o    <= 1'b0;
    end else begin
      tim_tick_o <= tick0_i;
      xclk_o     <= lvl & ~off_i;
      start_o    <= start;
    end
  end
endmodule

// File: rtl/bclk_gen.sv
module bclk_gen
  import bclk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tim_div2_i,
  input  logic ext_div2_i,
  input  logic ext_off_i,
  output logic tim_tick_o,
  output logic xclk_o,
  output logic acc_start_o
);
  bclk_cfg_t       cfg_d, cfg_q;
  logic [NSTG:0]   en;
  logic [NSTG-1:0] at_first;
  logic            ext_end;

  assign cfg_d.off  = ext_off_i;
  assign cfg_d.half = {ext_div2_i, tim_div2_i};

  assign en[0]   = 1'b1;
  assign ext_end = en[NSTG];

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    bclk_div_stage u_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (en[g]),
      .half_i     (cfg_q.half[g]),
      .tick_o     (en[g+1]),
      .at_first_o (at_first[g])
    );
  end

  bclk_cfg_hold u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ext_end),
    .cfg_i  (cfg_d),
    .cfg_o  (cfg_q)
  );

  bclk_out_shaper u_shape (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick0_i    (en[1]),
    .at_first_i (at_first),
    .half_i     (cfg_q.half),
    .off_i      (cfg_q.off),
    .tim_tick_o (tim_tick_o),
    .xclk_o     (xclk_o),
    .start_o    (acc_start_o)
  );

  a_r8_rise_has_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xclk_o && !$past(xclk_o)) |-> acc_start_o);

  a_r6_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.off |=> !xclk_o);

  a_r7_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_end |=> $stable(cfg_q));

  a_r4_start_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_start_o && $past(|cfg_q.half)) |=> !acc_start_o);
endmodule

// File: tb/tb_bclk_gen.sv
module tb_bclk_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tim_div2 = 1'b1, ext_div2 = 1'b1, ext_off = 1'b0;
  logic tim_tick, xclk, acc_start;

  int n_chk = 0, n_bad = 0;
  int k = 0;
  bit mt = 1, me = 1, moff = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bclk_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .tim_div2_i(tim_div2), .ext_div2_i(ext_div2),
    .ext_off_i(ext_off), .tim_tick_o(tim_tick), .xclk_o(xclk), .acc_start_o(acc_start)
  );

  function automatic int period(bit t, bit e);
    return (t ? 2 : 1) * (e ? 2 : 1);
  endfunction

  function automatic bit [2:0] decode(int kk, bit t, bit e, bit off);
    int p = period(t, e);
    bit tk = t ? (kk % 2 == 1) : 1'b1;
    bit xc = !off && (kk < (p + 1) / 2);
    bit st = (kk == 0);
    return {tk, xc, st};
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // drive at falling edge, compare at the following falling edge (R11 latency)
  task automatic step(input bit t_in, input bit e_in, input bit off_in, input string phase);
    bit [2:0] ex;
    bit pend;
    string tt, tx, ts;
    int p;
    tim_div2 = t_in; ext_div2 = e_in; ext_off = off_in;
    ex   = decode(k, mt, me, moff);
    pend = (t_in != mt) || (e_in != me) || (off_in != moff);
    p    = period(mt, me);
    tt = pend ? "R7 tick" : (mt ? "R3 tick" : "R2 tick");
    tx = moff ? "R6 xclk" : (p == 1 ? "R9 xclk" : (pend ? "R7 xclk" : "R10 xclk"));
    ts = (p == 1) ? "R9 start" : (me ? "R4 start" : "R8 start");
    if (phase == "R5") begin tt = "R5 tick"; tx = "R5 xclk"; ts = "R5 start"; end
    if (k == p - 1) begin
      k = 0; mt = t_in; me = e_in; moff = off_in;
    end else k++;
    @(negedge clk);
    check(tim_tick, ex[2], tt);
    check(xclk, ex[1], tx);
    check(acc_start, ex[0], ts);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) begin
      @(negedge clk);
      check(tim_tick, 1'b0, "R1 tick");
      check(xclk, 1'b0, "R1 xclk");
      check(acc_start, 1'b0, "R1 start");
    end
    rst_n = 1'b1;
    // R5 default quarter rate
    for (int i = 0; i < 16; i++) step(1, 1, 0, "R5");
    // each ratio combination held steadily
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < 20; i++) step(c[0], c[1], 0, "dir");
    end
    // R9 full/full and R6 gate-off with ticks running
    for (int i = 0; i < 12; i++) step(0, 0, 0, "dir");
    for (int i = 0; i < 12; i++) step(1, 0, 1, "dir");
    for (int i = 0; i < 12; i++) step(0, 1, 1, "dir");
    // R7 single-cycle glitch on config in mid period
    for (int i = 0; i < 8; i++) step(1, 1, 0, "dir");
    step(0, 0, 1, "dir");
    for (int i = 0; i < 8; i++) step(1, 1, 0, "dir");
    // random with occasional changes
    for (int i = 0; i < 4000; i++) begin
      bit t = tim_div2, e = ext_div2, o = ext_off;
      if ($urandom_range(0, 5) == 0) t = $urandom_range(0, 1);
      if ($urandom_range(0, 5) == 0) e = $urandom_range(0, 1);
      if ($urandom_range(0, 9) == 0) o = $urandom_range(0, 1);
      step(t, e, o, "rnd");
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule